// File: doc/BRIEF.md
# Double-Buffered Configuration Bank with Frame-Synchronous Commit

This block holds a small bank of 32-bit configuration words in two copies. Software writes and reads only the staging (shadow) copy through a simple register port. The display pipeline sees only the live (active) copy. The live copy changes only at a vertical blanking strobe, so a half-written configuration never reaches the screen in the middle of a frame.

A control word sets up the commit. Writing its request bit arms a one-shot load. The bit then reads back as 1 until the next blanking strobe moves the shadow words into the live copy, and after that it reads 0. Software polls this bit before it starts the next group of writes. A second control bit turns off the automatic copy that otherwise happens at every blanking strobe.

The configuration words are not reset. After power-up, software must write every word of the bank before the first load.

Top module: `shcc_top`

## Requirements
- R1: After reset the control word at byte address 0 reads 0. Bit 0 is load-pending and bit 1 is autoload-off, so autoload is on. `load_pulse` is 0.
- R2: Configuration word k sits at byte address 4*(k+1), and a read returns its shadow value. Address bits [1:0] are ignored. Bits 31:2 of the control word read 0. Word addresses above the bank read 0, and a write to them changes no word.
- R3: A write to a shadow word does not change `active_cfg` until a load occurs.
- R4: Writing the control word with bit 0 set makes bit 0 read 1. The next `vblank` cycle copies every shadow word into `active_cfg`, and after that cycle bit 0 reads 0.
- R5: A pending load stays pending while no `vblank` arrives. A control write with bit 0 clear does not cancel it, although it still updates bit 1.
- R6: A load request written in the same cycle as a `vblank` strobe is served at the following `vblank`, not at that one.
- R7: With autoload off and no load pending, a `vblank` leaves `active_cfg` unchanged.
- R8: With autoload on, every `vblank` copies the shadow words into `active_cfg`, and the pending bit stays 0 if it was 0.
- R9: `load_pulse` is high for exactly the cycle after each load, in the same cycle in which the new `active_cfg` value appears.
- R10: A shadow write in the same cycle as a loading `vblank` does not reach `active_cfg` in that load. The new value stays in the shadow copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (6) | Byte address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| vblank | input | 1 | One-cycle vertical blanking strobe |
| active_cfg | output | NUM_WORDS*32 (256) | Live configuration; word k occupies bits [32k+31:32k] |
| load_pulse | output | 1 | High for one cycle when `active_cfg` has just been loaded |

## Verification
If the pending bit were wrong, a polled read of the control word would show the error in the very next cycle. It would also show at the next blanking strobe, as a load that happens when none was armed or one that is missing. If the load decision used the wrong state, `active_cfg` and `load_pulse` would differ from the expected copy one cycle after the `vblank` strobe. The scoreboard catches that on the first frame affected. If shadow-write decoding were corrupted, it would show at once in the read data, and in the live words only after a load.

// File: rtl/shcc_pkg.sv
package shcc_pkg;
  localparam int DATA_W        = 32;
  localparam int CTRL_PEND_BIT = 0;
  localparam int CTRL_AOFF_BIT = 1;

  typedef struct packed {
    logic auto_off;
    logic pend;
  } ctrl_t;
endpackage

// File: rtl/shcc_shadow_bank.sv
module shcc_shadow_bank #(
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic [NUM_WORDS-1:0]        word_we,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_WORDS*DATA_W-1:0] shadow
);
  genvar k;
  generate
    for (k = 0; k < NUM_WORDS; k++) begin : g_word
      logic [DATA_W-1:0] word_d;
      logic [DATA_W-1:0] word_q;
      always_comb begin
        word_d = word_q;
        if (word_we[k]) word_d = wdata;
      end
      always_ff @(posedge clk) begin
        if (word_we[k]) word_q <= word_d;
      end
      assign shadow[k*DATA_W +: DATA_W] = word_q;
    end
  endgenerate
endmodule

// File: rtl/shcc_active_bank.sv
module shcc_active_bank #(
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        load,
  input  logic [NUM_WORDS*DATA_W-1:0] shadow,
  output logic [NUM_WORDS*DATA_W-1:0] active
);
  genvar k;
  generate
    for (k = 0; k < NUM_WORDS; k++) begin : g_word
      logic [DATA_W-1:0] live_d;
      logic [DATA_W-1:0] live_q;
      always_comb begin
        live_d = live_q;
        if (load) live_d = shadow[k*DATA_W +: DATA_W];
      end
      always_ff @(posedge clk) begin
        if (load) live_q <= live_d;
      end
      assign active[k*DATA_W +: DATA_W] = live_q;
    end
  endgenerate
endmodule

// File: rtl/shcc_commit_ctrl.sv
module shcc_commit_ctrl
  import shcc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_we,
  input  logic  req_bit,
  input  logic  aoff_bit,
  input  logic  vblank,
  output ctrl_t ctrl,
  output logic  load
);
  ctrl_t ctrl_d;
  ctrl_t ctrl_q;

  assign load = vblank & (ctrl_q.pend | ~ctrl_q.auto_off);

  always_comb begin
    ctrl_d = ctrl_q;
    if (vblank) ctrl_d.pend = 1'b0;
    if (ctrl_we) begin
      ctrl_d.auto_off = aoff_bit;
      if (req_bit) ctrl_d.pend = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.pend && vblank && !(ctrl_we && req_bit)) |=> !ctrl.pend);
  assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.pend && !vblank) |=> ctrl.pend);
  assert_req_deferred_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && ctrl_we && req_bit) |=> ctrl.pend);
  assert_no_spurious_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && ctrl_q.auto_off && !ctrl_q.pend) |-> !load);
  assert_load_only_vblank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> vblank);
endmodule

// File: rtl/shcc_top.sv
module shcc_top
  import shcc_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  input  logic                        vblank,
  output logic [NUM_WORDS*DATA_W-1:0] active_cfg,
  output logic                        load_pulse
);
  localparam int IDX_W = ADDR_W - 2;

  logic [1:0]           rst_sync_q;
  logic                 rst_n_i;
  logic [IDX_W-1:0]     word_idx;
  logic                 ctrl_we;
  logic [NUM_WORDS-1:0] word_we;
  logic [NUM_WORDS*DATA_W-1:0] shadow;
  ctrl_t                ctrl;
  logic                 load;
  logic                 pulse_d;
  logic                 pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign word_idx = addr[ADDR_W-1:2];
  assign ctrl_we  = wr_en && (word_idx == '0);

  genvar k;
  generate
    for (k = 0; k < NUM_WORDS; k++) begin : g_dec
      assign word_we[k] = wr_en && (word_idx == IDX_W'(k + 1));
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (word_idx == '0) begin
      rdata[CTRL_PEND_BIT] = ctrl.pend;
      rdata[CTRL_AOFF_BIT] = ctrl.auto_off;
    end
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (word_idx == IDX_W'(i + 1)) rdata = shadow[i*DATA_W +: DATA_W];
    end
  end

  shcc_shadow_bank #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) i_shadow (
    .clk(clk), .word_we(word_we), .wdata(wdata), .shadow(shadow));

  shcc_commit_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n_i), .ctrl_we(ctrl_we),
    .req_bit(wdata[CTRL_PEND_BIT]), .aoff_bit(wdata[CTRL_AOFF_BIT]),
    .vblank(vblank), .ctrl(ctrl), .load(load));

  shcc_active_bank #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) i_active (
    .clk(clk), .load(load), .shadow(shadow), .active(active_cfg));

  assign pulse_d = load;
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) pulse_q <= 1'b0;
    else          pulse_q <= pulse_d;
  end
  assign load_pulse = pulse_q;

  assert_pulse_follows_vblank_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    load_pulse |-> $past(vblank));
  assert_pulse_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    load |=> load_pulse);
  assert_idle_ctrl_reset_R1: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(rst_n_i) |-> (ctrl == '0));
endmodule

// File: tb/test_shcc_top.sv
module test_shcc_top;
  localparam int NW = 8;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic vblank = 1'b0;
  logic [NW*DW-1:0] active_cfg;
  logic load_pulse;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] shadow_m [NW];
  logic [NW*DW-1:0] active_m;
  logic [NW*DW-1:0] exp_q [$];
  logic pend_m;
  logic aoff_m;
  bit done = 0;

  always #10 clk = ~clk;

  shcc_top #(.NUM_WORDS(NW), .ADDR_W(AW)) i_shcc_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .vblank(vblank), .active_cfg(active_cfg), .load_pulse(load_pulse));

  task automatic chk(input bit ok, input string req, input logic [NW*DW-1:0] act,
                     input logic [NW*DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each load pulse pops one expected live image (R9)
  always @(negedge clk) begin
    if (rst_n && load_pulse) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected load_pulse", active_cfg, '0);
      else begin
        logic [NW*DW-1:0] e;
        e = exp_q.pop_front();
        chk(active_cfg === e, "R9 live image at load_pulse", active_cfg, e);
      end
    end
  end

  function automatic logic [NW*DW-1:0] pack_shadow();
    logic [NW*DW-1:0] r;
    for (int i = 0; i < NW; i++) r[i*DW +: DW] = shadow_m[i];
    return r;
  endfunction

  // one clock cycle: optional write and optional vblank, model updated per requirements
  task automatic step(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit vb);
    bit ld;
    wr_en = we; addr = a; wdata = d; vblank = vb;
    ld = vb && (pend_m || !aoff_m);
    if (ld) begin
      active_m = pack_shadow();
      exp_q.push_back(active_m);
    end
    if (vb) pend_m = 1'b0;
    if (we) begin
      if (a[AW-1:2] == 0) begin
        aoff_m = d[1];
        if (d[0]) pend_m = 1'b1;
      end else if (int'(a[AW-1:2]) <= NW) shadow_m[int'(a[AW-1:2]) - 1] = d;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; vblank = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
    wr_en = 1'b0; vblank = 1'b0; addr = a;
    #1;
    chk(rdata === e, req, {{(NW-1)*DW{1'b0}}, rdata}, {{(NW-1)*DW{1'b0}}, e});
  endtask

  task automatic live_chk(input string req);
    chk(active_cfg === active_m, req, active_cfg, active_m);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pend_m = 1'b0; aoff_m = 1'b0; active_m = '0;
    for (int i = 0; i < NW; i++) shadow_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd_chk(0, 32'h0, "R1 control word after reset");
    chk(load_pulse === 1'b0, "R1 load_pulse after reset", {255'b0, load_pulse}, '0);

    // autoload off, then clear every word and commit
    step(1, 0, 32'h2, 0);
    for (int i = 0; i < NW; i++) step(1, AW'(4*(i+1)), 32'h0, 0);
    step(1, 0, 32'h3, 0);
    step(0, 0, 0, 1);
    live_chk("R4 cleared bank loaded");

    // R2: shadow read-back, byte offset ignored, out-of-range
    for (int i = 0; i < NW; i++) step(1, AW'(4*(i+1)), 32'hA500_0000 + i, 0);
    for (int i = 0; i < NW; i++) rd_chk(AW'(4*(i+1) + 2), 32'hA500_0000 + i, "R2 shadow read");
    step(1, AW'(4*(NW+1)), 32'hDEAD_BEEF, 0);
    rd_chk(AW'(4*(NW+1)), 32'h0, "R2 out-of-range read");
    rd_chk(AW'(4*NW), 32'hA500_0000 + NW - 1, "R2 out-of-range write ignored");
    rd_chk(4, 32'hA500_0000, "R2 first word untouched");
    step(1, 0, 32'hFFFF_FFF2, 0);
    rd_chk(0, 32'h2, "R2 control upper bits read 0");

    // R3 / R7
    live_chk("R3 shadow writes not visible");
    step(0, 0, 0, 1);
    live_chk("R7 vblank without request");

    // R4 / R5
    step(1, 0, 32'h3, 0);
    rd_chk(0, 32'h3, "R4 pending reads 1");
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    step(1, 0, 32'h2, 0);
    rd_chk(0, 32'h3, "R5 pending kept after bit0=0 write");
    step(0, 0, 0, 1);
    rd_chk(0, 32'h2, "R4 pending cleared after load");
    live_chk("R4 live after load");

    // R6: request in same cycle as vblank
    step(1, 4, 32'h1111_0000, 0);
    step(1, 0, 32'h3, 1);
    live_chk("R6 no load on coinciding vblank");
    rd_chk(0, 32'h3, "R6 request still pending");
    step(0, 0, 0, 1);
    live_chk("R6 load at following vblank");
    rd_chk(0, 32'h2, "R6 pending cleared");

    // R10: shadow write with loading vblank
    step(1, 0, 32'h3, 0);
    step(1, 8, 32'h2222_0000, 1);
    live_chk("R10 load took previous shadow");
    rd_chk(8, 32'h2222_0000, "R10 new value in shadow");
    step(1, 0, 32'h3, 0);
    step(0, 0, 0, 1);
    live_chk("R10 new value loaded next");

    // R8: autoload on
    step(1, 0, 32'h0, 0);
    step(1, 12, 32'h3333_0000, 0);
    live_chk("R3 before autoload vblank");
    step(0, 0, 0, 1);
    live_chk("R8 autoload copy");
    rd_chk(0, 32'h0, "R8 pending stays 0");
    step(1, 16, 32'h4444_0000, 1);
    step(0, 0, 0, 1);
    live_chk("R8 back-to-back autoload");

    step(0, 0, 0, 0); step(0, 0, 0, 0);
    chk(exp_q.size() == 0, "R9 every load produced a pulse", exp_q.size(), 0);
    chk(load_pulse === 1'b0, "R9 pulse low when idle", {255'b0, load_pulse}, '0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule